// File: doc/BRIEF.md
# SPI Status Register Write Protection

This block is the status-register write path of an SPI serial memory slave. It watches the serial clock, chip select, serial data in and the hardware write-protect pin, all resynchronised into the system clock domain. Frames are shifted in most significant bit first, one bit per rising serial clock edge while chip select is low, so SPI modes 0 and 3 both work. A frame holding only an enable opcode arms a write-enable latch. A later frame with the write-status opcode carries the new value of the main status register and, optionally, the secondary one.

Nothing is written while the frame is in progress. Every decision is taken when chip select rises. At that point the block checks that the frame ended on a byte boundary, that the latch was armed and that the write-protect pin and the lock bit allow the write. The write-protect pin is sampled at that same edge. The two registers are driven straight to output ports so that the rest of the memory can use the protect bits.

Top module: `spi_status_guard`

## Requirements
- R1: While `rst` is high and on the cycle after, `stat_main` and `stat_aux` read 0x00 and the write-enable latch is clear.
- R2: Writable bits of `stat_main` are bit 2 (block protect 0), bit 3 (block protect 1) and bit 7 (lock). All other bits always read 0, so a written value is masked with 0x8C.
- R3: A frame of exactly 8 bits holding 0x06 or 0x50 arms the latch. A write-status frame (first byte 0x01) that arrives while the latch is clear changes neither register.
- R4: Any frame whose first complete byte is 0x01 clears the latch when it ends, whether or not it commits. A second write-status frame with no new enable frame is ignored.
- R5: A write-status frame with two data bytes also loads `stat_aux` from the second byte, masked with 0x03 (bit 0 top protect, bit 1 bottom protect). With one data byte, `stat_aux` is unchanged.
- R6: Neither register changes while chip select is low. The commit happens only after chip select rises.
- R7: If the protect pin is low and lock bit 7 is 1 at the end of the frame, the whole write-status frame is ignored.
- R8: If the protect pin is low and lock bit 7 is 0, one frame may set the lock bit and change the other protect bits of both registers in the same commit.
- R9: If the protect pin is high, every writable bit, the lock bit included, may be set or cleared.
- R10: A write-status frame that ends off a byte boundary, or that carries fewer than 8 data bits, changes neither register.
- R11: The protect pin level that counts is the one present when chip select rises. Earlier levels within the frame do not matter.
- R12: Frames are accepted with the serial clock idling low (mode 0) or high (mode 3).
- R13: Bytes after the second data byte are ignored. The first two data bytes still commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, asynchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| stat_main | output | 8 | Main status register |
| stat_aux | output | 8 | Secondary status register |

## Verification
A change on a pin passes two synchroniser flops and one edge-detect comparison. The frame summary is then registered one cycle after chip select rises, and the registers update on the cycle after that. A commit is therefore due about four clk cycles after the chip select pin goes high. The bench waits eight cycles after each rise before it samples, and it samples on the falling clk edge. For R6 it samples again while chip select is still low, at least eight cycles after the last serial clock edge, so that any early update would already be visible.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WREN   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_EWSR   = 8'h50;
    localparam logic [BYTE_W-1:0] OP_WRSR   = 8'h01;

    localparam int BIT_BP0  = 2;
    localparam int BIT_BP1  = 3;
    localparam int BIT_LOCK = 7;
    localparam int BIT_TOP  = 0;
    localparam int BIT_BOT  = 1;

    localparam logic [BYTE_W-1:0] MAIN_MASK =
        (8'h1 << BIT_BP0) | (8'h1 << BIT_BP1) | (8'h1 << BIT_LOCK);
    localparam logic [BYTE_W-1:0] AUX_MASK =
        (8'h1 << BIT_TOP) | (8'h1 << BIT_BOT);

    // byte count saturates at three: opcode, data0, data1 (or more)
    typedef enum logic [1:0] {
        NB_NONE = 2'd0,
        NB_OP   = 2'd1,
        NB_ONE  = 2'd2,
        NB_TWO  = 2'd3
    } nbytes_e;

    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic [BYTE_W-1:0] data0;
        logic [BYTE_W-1:0] data1;
        nbytes_e           nbytes;
        logic              aligned;
        logic              wp_n;
    } frame_t;

    function automatic logic is_enable(input frame_t f);
        return f.aligned && (f.nbytes == NB_OP) &&
               ((f.opcode == OP_WREN) || (f.opcode == OP_EWSR));
    endfunction

    function automatic logic is_wrsr(input frame_t f);
        return (f.nbytes != NB_NONE) && (f.opcode == OP_WRSR);
    endfunction

    function automatic logic lock_blocks(input frame_t f, input logic lock_bit);
        return !f.wp_n && lock_bit;
    endfunction

endpackage

// File: rtl/ssg_sync.sv
module ssg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= {STAGES{rst_val[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain_q[LAST];
    end

endmodule

// File: rtl/ssg_frame_rx.sv
module ssg_frame_rx
    import ssg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sck_s,
    input  logic   cs_n_s,
    input  logic   si_s,
    input  logic   wp_n_s,
    output logic   frm_valid,
    output frame_t frm
);
    localparam int BIT_CW = $clog2(BYTE_W);

    logic              sck_prev_q;
    logic              cs_prev_q;
    logic              sck_rise;
    logic              cs_rise;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_nxt;
    logic [BIT_CW-1:0] bit_q;
    nbytes_e           byte_q;
    logic [BYTE_W-1:0] op_q;
    logic [BYTE_W-1:0] d0_q;
    logic [BYTE_W-1:0] d1_q;
    logic              byte_done;

    assign sck_rise  = sck_s && !sck_prev_q && !cs_n_s;
    assign cs_rise   = cs_n_s && !cs_prev_q;
    assign shift_nxt = {shift_q[BYTE_W-2:0], si_s};
    assign byte_done = sck_rise && (bit_q == BIT_CW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev_q <= 1'b0;
            cs_prev_q  <= 1'b1;
        end else begin
            sck_prev_q <= sck_s;
            cs_prev_q  <= cs_n_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            bit_q   <= '0;
            byte_q  <= NB_NONE;
            op_q    <= '0;
            d0_q    <= '0;
            d1_q    <= '0;
        end else if (cs_n_s) begin
            bit_q  <= '0;
            byte_q <= NB_NONE;
        end else if (sck_rise) begin
            shift_q <= shift_nxt;
            bit_q   <= bit_q + 1'b1;
            if (byte_done) begin
                unique case (byte_q)
                    NB_NONE: op_q <= shift_nxt;
                    NB_OP:   d0_q <= shift_nxt;
                    NB_ONE:  d1_q <= shift_nxt;
                    default: ;
                endcase
                if (byte_q != NB_TWO) begin
                    byte_q <= nbytes_e'(byte_q + 2'd1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            frm_valid <= cs_rise;
            if (cs_rise) begin
                frm.opcode  <= op_q;
                frm.data0   <= d0_q;
                frm.data1   <= d1_q;
                frm.nbytes  <= byte_q;
                frm.aligned <= (bit_q == '0);
                frm.wp_n    <= wp_n_s;
            end
        end
    end

endmodule

// File: rtl/ssg_reg_ctrl.sv
module ssg_reg_ctrl
    import ssg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  frame_t            frm,
    output logic              wel,
    output logic [BYTE_W-1:0] stat_main,
    output logic [BYTE_W-1:0] stat_aux
);
    logic commit;

    assign commit = frm_valid && is_wrsr(frm) && wel && frm.aligned &&
                    (frm.nbytes inside {NB_ONE, NB_TWO}) &&
                    !lock_blocks(frm, stat_main[BIT_LOCK]);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
        end else if (frm_valid) begin
            if (is_enable(frm)) begin
                wel <= 1'b1;
            end else if (is_wrsr(frm)) begin
                wel <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_main <= '0;
            stat_aux  <= '0;
        end else if (commit) begin
            stat_main <= frm.data0 & MAIN_MASK;
            if (frm.nbytes == NB_TWO) begin
                stat_aux <= frm.data1 & AUX_MASK;
            end
        end
    end

endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
    import ssg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic       wp_n,
    output logic [7:0] stat_main,
    output logic [7:0] stat_aux
);
    localparam int N_PINS = 4;

    logic [N_PINS-1:0] pins_s;
    logic              frm_valid;
    frame_t            frm;
    logic              wel;

    ssg_sync #(
        .WIDTH  (N_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .rst_val (4'b1010),
        .d       ({wp_n, cs_n, si, sck}),
        .q       (pins_s)
    );

    ssg_frame_rx rx_i (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (pins_s[0]),
        .si_s      (pins_s[1]),
        .cs_n_s    (pins_s[2]),
        .wp_n_s    (pins_s[3]),
        .frm_valid (frm_valid),
        .frm       (frm)
    );

    ssg_reg_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .frm       (frm),
        .wel       (wel),
        .stat_main (stat_main),
        .stat_aux  (stat_aux)
    );

endmodule

// File: rtl/spi_status_guard_chk.sv
module spi_status_guard_chk
    import ssg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       frm_valid,
    input frame_t     frm,
    input logic       wel,
    input logic [7:0] stat_main,
    input logic [7:0] stat_aux
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (stat_main == 8'h00) && (stat_aux == 8'h00) && !wel);

    p_no_latch_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !wel) |=> ($stable(stat_main) && $stable(stat_aux)));

    p_latch_cleared_r4: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm.nbytes != NB_NONE && frm.opcode == OP_WRSR) |=> !wel);

    p_update_after_frame_r6: assert property (@(posedge clk) disable iff (rst)
        ((stat_main != $past(stat_main)) || (stat_aux != $past(stat_aux)))
            |-> $past(frm_valid));

    p_locked_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm.wp_n && stat_main[BIT_LOCK])
            |=> ($stable(stat_main) && $stable(stat_aux)));

endmodule

bind spi_status_guard spi_status_guard_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm       (frm),
    .wel       (wel),
    .stat_main (stat_main),
    .stat_aux  (stat_aux)
);

// File: tb/spi_status_guard_tb_top.sv
module spi_status_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    logic [7:0] stat_main;
    logic [7:0] stat_aux;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  m3       = 1'b0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    spi_status_guard dut_i (
        .clk       (clk),
        .rst       (rst),
        .sck       (sck),
        .cs_n      (cs_n),
        .si        (si),
        .wp_n      (wp_n),
        .stat_main (stat_main),
        .stat_aux  (stat_aux)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_frame();
        @(negedge clk);
        sck = m3;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            if (m3) begin
                sck = 1'b0;
                si  = bits[31-i];
                wait_clk(4);
                sck = 1'b1;
                wait_clk(4);
            end else begin
                si  = bits[31-i];
                wait_clk(4);
                sck = 1'b1;
                wait_clk(4);
                sck = 1'b0;
            end
        end
    endtask

    task automatic close_frame();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        open_frame();
        send_bits(bits, n);
        close_frame();
    endtask

    task automatic enable(input logic [7:0] op);
        frame({op, 24'h0}, 8);
    endtask

    task automatic t_reset();
        check("R1 main after reset", stat_main, 8'h00);
        check("R1 aux after reset", stat_aux, 8'h00);
        frame({8'h01, 8'h0C, 16'h0}, 16);
        check("R1 latch clear after reset", stat_main, 8'h00);
    endtask

    task automatic t_basic();
        enable(8'h06);
        frame({8'h01, 8'h7F, 16'h0}, 16);
        check("R2 masked main write", stat_main, 8'h0C);
        check("R5 aux unchanged with one byte", stat_aux, 8'h00);
        enable(8'h50);
        frame({8'h01, 8'h00, 8'hFF, 8'h0}, 24);
        check("R5 main with two bytes", stat_main, 8'h00);
        check("R5 aux masked write", stat_aux, 8'h03);
    endtask

    task automatic t_latch();
        frame({8'h01, 8'h0C, 16'h0}, 16);
        check("R3 no enable ignored", stat_main, 8'h00);
        enable(8'h06);
        frame({8'h01, 8'h04, 16'h0}, 16);
        check("R4 first write", stat_main, 8'h04);
        frame({8'h01, 8'h08, 16'h0}, 16);
        check("R4 latch cleared", stat_main, 8'h04);
    endtask

    task automatic t_commit_at_end();
        enable(8'h06);
        open_frame();
        send_bits({8'h01, 8'h08, 8'h02, 8'h0}, 24);
        wait_clk(8);
        check("R6 main held while selected", stat_main, 8'h04);
        check("R6 aux held while selected", stat_aux, 8'h03);
        close_frame();
        check("R6 main after rise", stat_main, 8'h08);
        check("R6 aux after rise", stat_aux, 8'h02);
    endtask

    task automatic t_short();
        enable(8'h06);
        frame({8'h01, 8'h0C, 16'h0}, 12);
        check("R10 misaligned ignored", stat_main, 8'h08);
        enable(8'h06);
        frame({8'h01, 24'h0}, 8);
        check("R10 no data ignored", stat_main, 8'h08);
        enable(8'h06);
        frame({8'h01, 8'h04, 8'h01, 8'h0}, 23);
        check("R10 misaligned aux ignored", stat_aux, 8'h02);
    endtask

    task automatic t_lock();
        wp_n = 1'b0;
        enable(8'h06);
        frame({8'h01, 8'h88, 8'h01, 8'h0}, 24);
        check("R8 lock set main", stat_main, 8'h88);
        check("R8 lock set aux", stat_aux, 8'h01);
        enable(8'h06);
        frame({8'h01, 8'h00, 8'h02, 8'h0}, 24);
        check("R7 locked main", stat_main, 8'h88);
        check("R7 locked aux", stat_aux, 8'h01);
        enable(8'h06);
        open_frame();
        send_bits({8'h01, 8'h00, 8'h00, 8'h0}, 24);
        wp_n = 1'b1;
        close_frame();
        check("R11 pin high at rise main", stat_main, 8'h00);
        check("R9 lock cleared aux", stat_aux, 8'h00);
        enable(8'h06);
        frame({8'h01, 8'h84, 16'h0}, 16);
        check("R9 lock set with pin high", stat_main, 8'h84);
        enable(8'h06);
        open_frame();
        send_bits({8'h01, 8'h00, 16'h0}, 16);
        wp_n = 1'b0;
        close_frame();
        check("R11 pin low at rise", stat_main, 8'h84);
        wp_n = 1'b1;
        enable(8'h06);
        frame({8'h01, 8'h00, 16'h0}, 16);
        check("R9 unlock", stat_main, 8'h00);
    endtask

    task automatic t_mode3();
        m3 = 1'b1;
        enable(8'h50);
        frame({8'h01, 8'h0C, 8'h02, 8'h0}, 24);
        check("R12 mode 3 main", stat_main, 8'h0C);
        check("R12 mode 3 aux", stat_aux, 8'h02);
        m3 = 1'b0;
        @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic t_extra();
        enable(8'h06);
        frame({8'h01, 8'h08, 8'h01, 8'hFF}, 32);
        check("R13 extra bytes main", stat_main, 8'h08);
        check("R13 extra bytes aux", stat_aux, 8'h01);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        t_reset();
        t_basic();
        t_latch();
        t_commit_at_end();
        t_short();
        t_lock();
        t_mode3();
        t_extra();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule